// File: doc/BRIEF.md
# Flag-Propagation Routing Table Rebuilder

Each router of a two-dimensional mesh holds one copy of this block. After a link fault appears, it rebuilds one entry of the router's routing table. All routers start a pass for the same destination together and then run in lockstep rounds. In each round, a router that already knows a way to the destination raises a one-bit flag toward its neighbours. A router that does not yet know a way picks up the first flags it receives and records the port they came in on as its outgoing direction.

Faulty links carry no flags in either direction. A programmable mask of banned turns stops a router from advertising its route toward selected ports, which breaks the cycles that could otherwise deadlock traffic. After N-1 rounds for an N-router mesh, the block issues one write to the routing table. The write carries the destination, a valid bit and the chosen direction. A write with the valid bit clear means the destination cannot be reached from this router.

Top module: `flag_route_rebuilder`

## Requirements
- R1: A start strobe accepted while idle sets the entry valid with direction local (code 0) when `ownId` equals `destId`, and sets it invalid otherwise.
- R2: A round is two cycles: a transmit cycle, then an update cycle. In a transmit cycle, a router with a valid entry drives `flagOut` on each port that is not faulty and not banned. A router with an invalid entry drives nothing. `flagOut` is zero in update cycles and while idle.
- R3: Ports are numbered North 0, East 1, South 2, West 3 in every four-bit vector. Direction codes are local 0, North 1, East 2, South 3, West 4. An invalid router that captured at least one flag in the transmit cycle becomes valid in the following update, taking the direction of the arrival port.
- R4: When several flags are captured in the same round, the direction is chosen in the order South, East, West, North.
- R5: A valid entry never changes again during the pass. Flags present on `flagIn` outside transmit cycles have no effect.
- R6: A port whose `linkFault` bit is set never drives a flag, and flags arriving on it are ignored.
- R7: Bit 4*B+A of `turnBan` suppresses the flag on port A while the entry points out of port B. A local entry is never suppressed. The northeast corner rule is the value 16'h0012.
- R8: `done` and `tblWe` pulse together for exactly one cycle. This happens in the cycle after the 2*(N-1)-th clock edge that follows the start edge. At that point `tblDest` equals the `destId` captured at start, and `tblValid` and `tblDir` give the result. An entry that is still invalid is written with `tblValid` = 0.
- R9: A start strobe during a pass is ignored.
- R10: After reset, `flagOut`, `done` and `tblWe` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a pass for `destId` |
| ownId | input | ID_W | Identifier of this router |
| destId | input | ID_W | Destination under analysis |
| linkFault | input | 4 | Per-port fault mask, N/E/S/W = bits 0..3 |
| turnBan | input | 16 | Banned turns, bit 4*out+flag |
| flagIn | input | 4 | Flags from the neighbours |
| flagOut | output | 4 | Flags to the neighbours |
| tblWe | output | 1 | Table write strobe |
| tblDest | output | ID_W | Table write address |
| tblValid | output | 1 | Table entry valid |
| tblDir | output | 3 | Table entry direction code |
| done | output | 1 | Pass complete, one cycle |

## Verification
The start strobe is seen at one edge, and the flags it causes appear on `flagOut` in the next cycle. A flag presented in a transmit cycle is captured at the closing edge of that cycle. It takes effect at the edge after that, so it first shows on `flagOut` in the next round's transmit cycle. The bench moves round by round on the falling edge: it drives `flagIn`, checks `flagOut` against its own model in each transmit and update cycle, and holds `flagIn` at all ones during update cycles to prove they are ignored. It expects the table write exactly 2*(N-1)+1 cycles after the start edge, and checks that `done` is low one cycle later.

// File: rtl/rb_pkg.sv
package rb_pkg;

  localparam int PORTS = 4;
  localparam int PORT_N = 0;
  localparam int PORT_E = 1;
  localparam int PORT_S = 2;
  localparam int PORT_W = 3;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_EAST  = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;

  // strobes from control to datapath
  typedef struct packed {
    logic init;
    logic xmit;
    logic capture;
    logic update;
  } rb_strobe_t;

  // fixed tie-break: South, East, West, North
  function automatic dir_e pickDir(input logic [PORTS-1:0] seen);
    if (seen[PORT_S])      return DIR_SOUTH;
    else if (seen[PORT_E]) return DIR_EAST;
    else if (seen[PORT_W]) return DIR_WEST;
    else                   return DIR_NORTH;
  endfunction

endpackage

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
#(
  parameter int ROUNDS = 15,
  parameter int CNT_W  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output rb_strobe_t stb,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_XMIT, S_UPDT, S_FIN} state_e;

  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

  state_e state, stateNxt;
  logic [CNT_W-1:0] rndCnt;
  logic lastRnd;

  assign lastRnd = (rndCnt == LAST_RND);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          stb.init = 1'b1;
          stateNxt = S_XMIT;
        end
      end
      S_XMIT: begin
        stb.xmit    = 1'b1;
        stb.capture = 1'b1;
        stateNxt    = S_UPDT;
      end
      S_UPDT: begin
        stb.update = 1'b1;
        stateNxt   = lastRnd ? S_FIN : S_XMIT;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign done = (state == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rndCnt <= '0;
    end else begin
      state <= stateNxt;
      if (stb.init)        rndCnt <= '0;
      else if (stb.update) rndCnt <= rndCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rb_path.sv
module rb_path
  import rb_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rb_strobe_t       stb,
  input  logic [ID_W-1:0]  ownId,
  input  logic [ID_W-1:0]  destId,
  input  logic [PORTS-1:0] linkFault,
  input  logic [PORTS*PORTS-1:0] turnBan,
  input  logic [PORTS-1:0] flagIn,
  output logic [PORTS-1:0] flagOut,
  output logic             entryValid,
  output dir_e             entryDir,
  output logic [PORTS-1:0] flagSeen,
  output logic [ID_W-1:0]  destHeld
);

  logic [PORTS-1:0] banRow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entryValid <= 1'b0;
      entryDir   <= DIR_LOCAL;
      flagSeen   <= '0;
      destHeld   <= '0;
    end else if (stb.init) begin
      entryValid <= (ownId == destId);
      entryDir   <= DIR_LOCAL;
      flagSeen   <= '0;
      destHeld   <= destId;
    end else begin
      if (stb.capture) flagSeen <= flagIn & ~linkFault;
      if (stb.update && !entryValid && (|flagSeen)) begin
        entryValid <= 1'b1;
        entryDir   <= pickDir(flagSeen);
      end
    end
  end

  // row of banned flag ports for the current outgoing direction
  always_comb begin
    case (entryDir)
      DIR_NORTH: banRow = turnBan[PORT_N*PORTS +: PORTS];
      DIR_EAST:  banRow = turnBan[PORT_E*PORTS +: PORTS];
      DIR_SOUTH: banRow = turnBan[PORT_S*PORTS +: PORTS];
      DIR_WEST:  banRow = turnBan[PORT_W*PORTS +: PORTS];
      default:   banRow = '0;
    endcase
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_flag
    assign flagOut[p] = stb.xmit & entryValid & ~linkFault[p] & ~banRow[p];
  end

endmodule

// File: rtl/flag_route_rebuilder.sv
module flag_route_rebuilder
  import rb_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  localparam int NODES  = MESH_X * MESH_Y,
  localparam int ID_W   = $clog2(NODES),
  localparam int ROUNDS = NODES - 1,
  localparam int CNT_W  = $clog2(NODES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] ownId,
  input  logic [ID_W-1:0] destId,
  input  logic [3:0]      linkFault,
  input  logic [15:0]     turnBan,
  input  logic [3:0]      flagIn,
  output logic [3:0]      flagOut,
  output logic            tblWe,
  output logic [ID_W-1:0] tblDest,
  output logic            tblValid,
  output logic [2:0]      tblDir,
  output logic            done
);

  rb_strobe_t stb;
  logic       entryValid;
  dir_e       entryDir;
  logic [3:0] flagSeen;
  logic       initStb;

  rb_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) i_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .stb  (stb),
    .done (done)
  );

  rb_path #(.ID_W(ID_W)) i_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .ownId     (ownId),
    .destId    (destId),
    .linkFault (linkFault),
    .turnBan   (turnBan),
    .flagIn    (flagIn),
    .flagOut   (flagOut),
    .entryValid(entryValid),
    .entryDir  (entryDir),
    .flagSeen  (flagSeen),
    .destHeld  (tblDest)
  );

  assign initStb  = stb.init;
  assign tblWe    = done;
  assign tblValid = entryValid;
  assign tblDir   = entryDir;

endmodule

// File: rtl/rb_checker.sv
module rb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] flagOut,
  input logic [3:0] linkFault,
  input logic       done,
  input logic       entryValid,
  input logic       initStb,
  input logic [3:0] flagSeen
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_silent_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flagOut != 4'b0) |=> (flagOut == 4'b0));

  assert_fault_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flagOut & linkFault) == 4'b0);

  assert_entry_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (entryValid && !initStb) |=> entryValid);

  assert_valid_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(entryValid) && !$past(initStb)) |-> ($past(flagSeen) != 4'b0));

endmodule

bind flag_route_rebuilder rb_checker i_rbChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flagOut   (flagOut),
  .linkFault (linkFault),
  .done      (done),
  .entryValid(entryValid),
  .initStb   (initStb),
  .flagSeen  (flagSeen)
);

// File: tb/test_flag_route_rebuilder.sv
module test_flag_route_rebuilder;

  localparam int MX = 2;
  localparam int MY = 2;
  localparam int NODES = MX * MY;
  localparam int IDW = $clog2(NODES);
  localparam int ROUNDS = NODES - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [IDW-1:0] ownId = '0;
  logic [IDW-1:0] destId = '0;
  logic [3:0]  linkFault = '0;
  logic [15:0] turnBan = '0;
  logic [3:0]  flagIn = '0;
  logic [3:0]  flagOut;
  logic        tblWe;
  logic [IDW-1:0] tblDest;
  logic        tblValid;
  logic [2:0]  tblDir;
  logic        done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic       mv;
  logic [2:0] md;

  always #4 clk = ~clk;

  flag_route_rebuilder #(.MESH_X(MX), .MESH_Y(MY)) i_flag_route_rebuilder (
    .clk(clk), .rst_n(rst_n), .start(start), .ownId(ownId), .destId(destId),
    .linkFault(linkFault), .turnBan(turnBan), .flagIn(flagIn),
    .flagOut(flagOut), .tblWe(tblWe), .tblDest(tblDest), .tblValid(tblValid),
    .tblDir(tblDir), .done(done)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expPick(input logic [3:0] s);
    if (s[2]) return 3'd3;
    if (s[1]) return 3'd2;
    if (s[3]) return 3'd4;
    return 3'd1;
  endfunction

  function automatic logic [3:0] expFlags(input logic v, input logic [2:0] d,
                                          input logic [3:0] flt, input logic [15:0] ban);
    logic [3:0] row;
    if (!v) return 4'b0;
    row = (d == 3'd0) ? 4'b0 : ban[(d - 3'd1) * 4 +: 4];
    return ~flt & ~row;
  endfunction

  // one full pass; fl holds flags for rounds 1..ROUNDS (round 1 in low nibble)
  task automatic runPass(input logic [IDW-1:0] own, input logic [IDW-1:0] dst,
                         input logic [3:0] flt, input logic [15:0] ban,
                         input logic [4*ROUNDS-1:0] fl, input bit midStart);
    logic [3:0] eff;
    @(negedge clk);
    ownId = own; destId = dst; linkFault = flt; turnBan = ban; start = 1'b1;
    mv = (own == dst); md = 3'd0;   // R1 model
    @(posedge clk);
    for (int r = 0; r < ROUNDS; r++) begin
      @(negedge clk);
      start = 1'b0;
      destId = dst;
      if (midStart && r == 1) begin
        start = 1'b1;                // R9: ignored while busy
        destId = dst + 1'b1;
      end
      flagIn = fl[4*r +: 4];
      check({12'b0, flagOut}, {12'b0, expFlags(mv, md, flt, ban)}, "R2/R6/R7 xmit flags");
      check({15'b0, done}, 16'b0, "R8 no early done");
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      destId = dst;
      flagIn = 4'hF;                 // R5: stray flags in update cycle
      check({12'b0, flagOut}, 16'b0, "R2 quiet update");
      eff = fl[4*r +: 4] & ~flt;
      if (!mv && eff != 4'b0) begin mv = 1'b1; md = expPick(eff); end  // R3 R4 R5
      @(posedge clk);
    end
    @(negedge clk);
    flagIn = 4'b0;
    check({15'b0, done}, 16'h1, "R8 done due");
    check({15'b0, tblWe}, 16'h1, "R8 table write");
    check({{(16-IDW){1'b0}}, tblDest}, {{(16-IDW){1'b0}}, dst}, "R8 table dest");
    check({15'b0, tblValid}, {15'b0, mv}, "R3/R8 table valid");
    if (mv) check({13'b0, tblDir}, {13'b0, md}, "R3/R4 table dir");
    @(negedge clk);
    check({15'b0, done}, 16'b0, "R8 done single cycle");
    check({12'b0, flagOut}, 16'b0, "R2 idle quiet");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({12'b0, flagOut}, 16'b0, "R10 reset flags");
    check({15'b0, done}, 16'b0, "R10 reset done");
    check({15'b0, tblWe}, 16'b0, "R10 reset write");
    rst_n = 1'b1;

    // R1: own router is the destination, local entry, all clear ports flagged
    for (int f = 0; f < 16; f++)
      for (int b = 0; b < 3; b++)
        runPass(2'd2, 2'd2, 4'(f), (b == 0) ? 16'h0 : (b == 1) ? 16'h0012 : 16'hFFFF,
                {4'hF, 4'hF, 4'hF}, 1'b0);

    // R3 R4 R6 R7: all first-round flag patterns against all fault masks
    for (int f = 0; f < 16; f++)
      for (int k = 0; k < 16; k++)
        for (int b = 0; b < 4; b++)
          runPass(2'd1, 2'd3, 4'(k),
                  (b == 0) ? 16'h0 : (b == 1) ? 16'h0012 : (b == 2) ? 16'hFFFF : 16'hA5C3,
                  {4'hF, ~4'(f), 4'(f)}, 1'b0);

    // R8: flags arriving only in the last round still produce a valid entry
    for (int f = 0; f < 16; f++)
      runPass(2'd0, 2'd1, 4'h0, 16'h0012, {4'(f), 4'h0, 4'h0}, 1'b0);

    // R8: no flags at all leaves the destination unreachable
    runPass(2'd3, 2'd0, 4'h0, 16'h0, {4'h0, 4'h0, 4'h0}, 1'b0);

    // R9: start in mid-pass is ignored
    runPass(2'd1, 2'd2, 4'h0, 16'h0012, {4'h0, 4'h4, 4'h1}, 1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule